// File: doc/BRIEF.md
# Host mailbox port

This block is a parallel mailbox between an asynchronous 8-bit host bus and the 16-bit data bus of a processor core. Six 16-bit mailbox registers are visible from both sides. Two status registers report which mailboxes the host has written and which it has read. A mask register, which only the core can reach, selects which mailboxes may raise interrupts. The core gets a write-done pulse and a read-done pulse, and either side can start a fixed-length software reset pulse.

Two static strap inputs select one of four host bus styles. The first strap picks either separate read and write strobes, or a read-not-write line with a single data strobe. The second strap picks either a separate 3-bit address bus, or an address placed on the data bus and captured while an address-latch-enable line is high. Host strobes and the address-latch enable are synchronised into the core clock. Each host access is acted on once, when its synchronised strobe ends.

Top module: `hmbx_port`

## Requirements
- R1: After reset, every mailbox, both status registers and the mask register read as zero, and `irq_wr_o`, `irq_rd_o` and `sw_rst_o` are low.
- R2: With `strap_rnw_i`=0, `h_rd_ds_ni` low is a host read and `h_wr_rnw_i` low is a host write. A host write to address n (0..5) loads the byte into bits 7:0 of mailbox n and clears bits 15:8. The core reads mailbox n at core address n.
- R3: With `strap_rnw_i`=1, `h_rd_ds_ni` is an active-low data strobe and `h_wr_rnw_i` selects a read (1) or a write (0). The mailbox contents are the same as in R2.
- R4: With `strap_mux_i`=1, the host address is taken from `h_ad_i[2:0]` while `h_ale_i` is high, and `h_addr_i` is ignored. Write data still comes from `h_ad_i` during the strobe.
- R5: A host write to mailbox n sets bit n of the write status register (core address 6, host address 6). A core read of mailbox n clears that bit.
- R6: During a host read, `h_data_oe_o` is high and `h_data_o` carries bits 7:0 of the addressed register. A host read of mailbox n sets bit n of the read status register (core address 7, host address 7). A core write to mailbox n clears that bit.
- R7: A host write to mailbox n raises `irq_wr_o` for exactly one cycle, but only if mask bit n (core address 8, bits 5:0) and `c_wr_irq_en_i` are both set.
- R8: A host read of mailbox n raises `irq_rd_o` for exactly one cycle, but only if mask bit 8+n and `c_rd_irq_en_i` are both set.
- R9: Writing 1 to bit 7 of the read status register, from the host (address 7) or from the core (address 7), drives `sw_rst_o` high for exactly 5 core cycles. Bit 7 reads as 1 while the pulse lasts.
- R10: A host write to address 6 or 7 changes no status bit, apart from starting the reset of R9.
- R11: A host strobe held active for many cycles produces exactly one event and one interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_rnw_i | input | 1 | 0: separate strobes; 1: read-not-write plus data strobe |
| strap_mux_i | input | 1 | 0: separate address bus; 1: address on data bus with latch enable |
| h_rd_ds_ni | input | 1 | Host read strobe or data strobe, active low |
| h_wr_rnw_i | input | 1 | Host write strobe (active low) or read-not-write select |
| h_ale_i | input | 1 | Host address latch enable (multiplexed style) |
| h_addr_i | input | 3 | Host address (separate style) |
| h_ad_i | input | 8 | Host write data, and address in multiplexed style |
| h_data_o | output | 8 | Host read data |
| h_data_oe_o | output | 1 | Host read data drive enable |
| c_addr_i | input | 4 | Core address: 0..5 mailboxes, 6 and 7 status, 8 mask |
| c_re_i | input | 1 | Core read strobe |
| c_we_i | input | 1 | Core write strobe |
| c_wdata_i | input | 16 | Core write data |
| c_rdata_o | output | 16 | Core read data |
| c_wr_irq_en_i | input | 1 | Global enable for write interrupts |
| c_rd_irq_en_i | input | 1 | Global enable for read interrupts |
| irq_wr_o | output | 1 | Write-done interrupt pulse |
| irq_rd_o | output | 1 | Read-done interrupt pulse |
| sw_rst_o | output | 1 | Software reset pulse |

## Verification
The bench builds the block with its default parameters: six mailboxes, two synchroniser stages and a five-cycle reset pulse. These defaults fill the 3-bit host address space, so both status addresses and every mailbox index can be reached from both sides. Random traffic changes the strap styles between accesses, so all four host bus styles run against the same mailbox state. The mask and enable settings are also randomised, which covers every combination of mask bit and global enable for both interrupt kinds.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
  localparam int HAW = 3;   // host address width
  localparam int CAW = 4;   // core address width
  localparam int HDW = 8;   // host data width
  localparam int DW  = 16;  // mailbox width

  typedef enum logic {STRB_SPLIT = 1'b0, STRB_RNW = 1'b1} strb_mode_e;
  typedef enum logic {BUS_SPLIT = 1'b0, BUS_MUX = 1'b1} bus_mode_e;
endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hmbx_host_fe.sv
module hmbx_host_fe
  import hmbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  strb_mode_e     strb_mode_i,
  input  bus_mode_e      bus_mode_i,
  input  logic           h_rd_ds_ni,
  input  logic           h_wr_rnw_i,
  input  logic           h_ale_i,
  input  logic [HAW-1:0] h_addr_i,
  input  logic [HDW-1:0] h_ad_i,
  output logic           rd_act_async_o,
  output logic [HAW-1:0] sel_addr_o,
  output logic           evt_wr_o,
  output logic           evt_rd_o,
  output logic [HAW-1:0] ev_addr_o,
  output logic [HDW-1:0] ev_data_o
);
  logic [2:0] pins_s;
  logic       a_s, b_s, ale_s;
  logic       rd_act_s, wr_act_s, rd_prev_q, wr_prev_q;
  logic [HAW-1:0] addr_q;
  logic [HDW-1:0] data_q;

  hmbx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({h_rd_ds_ni, h_wr_rnw_i, h_ale_i}),
    .q_o   (pins_s)
  );
  assign {a_s, b_s, ale_s} = pins_s;

  // decode after sync so both pins see the same latency
  always_comb begin
    if (strb_mode_i == STRB_RNW) begin
      rd_act_s = ~a_s & b_s;
      wr_act_s = ~a_s & ~b_s;
    end else begin
      rd_act_s = ~a_s;
      wr_act_s = ~b_s;
    end
  end

  assign rd_act_async_o = (strb_mode_i == STRB_RNW) ? (~h_rd_ds_ni & h_wr_rnw_i) : ~h_rd_ds_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      rd_prev_q <= rd_act_s;
      wr_prev_q <= wr_act_s;
      if (bus_mode_i == BUS_MUX) begin
        if (ale_s) addr_q <= h_ad_i[HAW-1:0];
      end else if (rd_act_s || wr_act_s) begin
        addr_q <= h_addr_i;
      end
      if (wr_act_s) data_q <= h_ad_i;
    end
  end

  assign evt_rd_o   = rd_prev_q & ~rd_act_s;
  assign evt_wr_o   = wr_prev_q & ~wr_act_s;
  assign ev_addr_o  = addr_q;
  assign ev_data_o  = data_q;
  assign sel_addr_o = (bus_mode_i == BUS_MUX) ? addr_q : h_addr_i;
endmodule

// File: rtl/hmbx_rst_pulse.sv
module hmbx_rst_pulse #(
  parameter int RST_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    else if (trig_i)            cnt_q <= CW'(RST_CYCLES);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/hmbx_port.sv
module hmbx_port
  import hmbx_pkg::*;
#(
  parameter int NUM_MBX     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           strap_rnw_i,
  input  logic           strap_mux_i,
  input  logic           h_rd_ds_ni,
  input  logic           h_wr_rnw_i,
  input  logic           h_ale_i,
  input  logic [2:0]     h_addr_i,
  input  logic [7:0]     h_ad_i,
  output logic [7:0]     h_data_o,
  output logic           h_data_oe_o,
  input  logic [3:0]     c_addr_i,
  input  logic           c_re_i,
  input  logic           c_we_i,
  input  logic [15:0]    c_wdata_i,
  output logic [15:0]    c_rdata_o,
  input  logic           c_wr_irq_en_i,
  input  logic           c_rd_irq_en_i,
  output logic           irq_wr_o,
  output logic           irq_rd_o,
  output logic           sw_rst_o
);
  localparam int WST_ADR  = NUM_MBX;
  localparam int RST_ADR  = NUM_MBX + 1;
  localparam int MASK_ADR = NUM_MBX + 2;
  localparam int RD_MOFS  = DW / 2;

  logic [DW-1:0]      hdr_q [NUM_MBX];
  logic [NUM_MBX-1:0] wst_q, rdst_q;
  logic [DW-1:0]      mask_q;
  logic               irq_wr_q, irq_rd_q;

  logic               evt_wr, evt_rd, rd_act;
  logic [HAW-1:0]     ev_addr, sel_addr;
  logic [HDW-1:0]     ev_data;
  logic [DW-1:0]      hsr_wst, hsr_rst;
  logic               ev_in_mbx, rst_trig;

  hmbx_host_fe #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strb_mode_i   (strb_mode_e'(strap_rnw_i)),
    .bus_mode_i    (bus_mode_e'(strap_mux_i)),
    .h_rd_ds_ni    (h_rd_ds_ni),
    .h_wr_rnw_i    (h_wr_rnw_i),
    .h_ale_i       (h_ale_i),
    .h_addr_i      (h_addr_i),
    .h_ad_i        (h_ad_i),
    .rd_act_async_o(rd_act),
    .sel_addr_o    (sel_addr),
    .evt_wr_o      (evt_wr),
    .evt_rd_o      (evt_rd),
    .ev_addr_o     (ev_addr),
    .ev_data_o     (ev_data)
  );

  assign ev_in_mbx = (int'(ev_addr) < NUM_MBX);
  assign rst_trig  = (evt_wr && ev_addr == HAW'(RST_ADR) && ev_data[7]) ||
                     (c_we_i && c_addr_i == CAW'(RST_ADR) && c_wdata_i[7]);

  hmbx_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (rst_trig),
    .pulse_o(sw_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_MBX; i++) hdr_q[i] <= '0;
      wst_q    <= '0;
      rdst_q   <= '0;
      mask_q   <= '0;
      irq_wr_q <= 1'b0;
      irq_rd_q <= 1'b0;
    end else begin
      irq_wr_q <= evt_wr && ev_in_mbx && mask_q[ev_addr] && c_wr_irq_en_i;
      irq_rd_q <= evt_rd && ev_in_mbx && mask_q[RD_MOFS + int'(ev_addr)] && c_rd_irq_en_i;
      if (c_we_i && c_addr_i == CAW'(MASK_ADR)) mask_q <= c_wdata_i;
      for (int i = 0; i < NUM_MBX; i++) begin
        // host events win over a same-cycle core access
        if (c_we_i && c_addr_i == CAW'(i)) begin
          hdr_q[i]  <= c_wdata_i;
          rdst_q[i] <= 1'b0;
        end
        if (c_re_i && c_addr_i == CAW'(i)) wst_q[i] <= 1'b0;
        if (evt_wr && ev_addr == HAW'(i)) begin
          hdr_q[i] <= {{(DW-HDW){1'b0}}, ev_data};
          wst_q[i] <= 1'b1;
        end
        if (evt_rd && ev_addr == HAW'(i)) rdst_q[i] <= 1'b1;
      end
    end
  end

  assign hsr_wst = DW'(wst_q);
  assign hsr_rst = DW'({sw_rst_o, 1'b0, rdst_q});

  always_comb begin
    c_rdata_o = '0;
    for (int i = 0; i < NUM_MBX; i++)
      if (c_addr_i == CAW'(i)) c_rdata_o = hdr_q[i];
    if (c_addr_i == CAW'(WST_ADR))  c_rdata_o = hsr_wst;
    if (c_addr_i == CAW'(RST_ADR))  c_rdata_o = hsr_rst;
    if (c_addr_i == CAW'(MASK_ADR)) c_rdata_o = mask_q;
  end

  always_comb begin
    h_data_o = '0;
    for (int i = 0; i < NUM_MBX; i++)
      if (sel_addr == HAW'(i)) h_data_o = hdr_q[i][HDW-1:0];
    if (sel_addr == HAW'(WST_ADR)) h_data_o = hsr_wst[HDW-1:0];
    if (sel_addr == HAW'(RST_ADR)) h_data_o = hsr_rst[HDW-1:0];
  end

  assign h_data_oe_o = rd_act;
  assign irq_wr_o    = irq_wr_q;
  assign irq_rd_o    = irq_rd_q;
endmodule

// File: rtl/hmbx_port_chk.sv
module hmbx_port_chk #(
  parameter int RST_CYCLES = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_wr_o,
  input logic irq_rd_o,
  input logic sw_rst_o,
  input logic c_wr_irq_en_i,
  input logic c_rd_irq_en_i
);
  localparam int RW = $clog2(RST_CYCLES + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (sw_rst_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  a_r9_rst_not_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |-> int'(run_q) < RST_CYCLES);
  a_r9_rst_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_rst_o) |-> int'(run_q) == RST_CYCLES);
  a_r7_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wr_o |=> !irq_wr_o);
  a_r8_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rd_o |=> !irq_rd_o);
  a_r7_wr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wr_o |-> $past(c_wr_irq_en_i));
  a_r8_rd_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rd_o |-> $past(c_rd_irq_en_i));
endmodule

bind hmbx_port hmbx_port_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/hmbx_port_tb.sv
module hmbx_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_rnw = 1'b0, strap_mux = 1'b0;
  logic h_rd_ds_n = 1'b1, h_wr_rnw = 1'b1, h_ale = 1'b0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_ad = '0, h_data;
  logic h_oe;
  logic [3:0] c_addr = '0;
  logic c_re = 1'b0, c_we = 1'b0;
  logic [15:0] c_wdata = '0, c_rdata;
  logic wen = 1'b0, ren = 1'b0;
  logic irq_wr, irq_rd, sw_rst;

  int n_chk = 0, n_fail = 0;
  int cnt_wr = 0, cnt_rd = 0, cnt_rst = 0;
  int exp_wr = 0, exp_rd = 0;
  logic [15:0] m_hdr [6];
  logic [5:0]  m_wst = '0, m_rdst = '0;
  logic [15:0] m_mask = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hmbx_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_rnw_i(strap_rnw), .strap_mux_i(strap_mux),
    .h_rd_ds_ni(h_rd_ds_n), .h_wr_rnw_i(h_wr_rnw), .h_ale_i(h_ale), .h_addr_i(h_addr),
    .h_ad_i(h_ad), .h_data_o(h_data), .h_data_oe_o(h_oe), .c_addr_i(c_addr),
    .c_re_i(c_re), .c_we_i(c_we), .c_wdata_i(c_wdata), .c_rdata_o(c_rdata),
    .c_wr_irq_en_i(wen), .c_rd_irq_en_i(ren), .irq_wr_o(irq_wr), .irq_rd_o(irq_rd),
    .sw_rst_o(sw_rst)
  );

  always @(posedge clk) begin
    if (irq_wr) cnt_wr++;
    if (irq_rd) cnt_rd++;
    if (sw_rst) cnt_rst++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_core(int a);
    if (a < 6)  return m_hdr[a];
    if (a == 6) return {10'b0, m_wst};
    if (a == 7) return {8'b0, 2'b00, m_rdst};
    if (a == 8) return m_mask;
    return '0;
  endfunction

  task automatic host_acc(bit is_wr, int a, logic [7:0] d, int hold, output logic [7:0] rd);
    @(negedge clk);
    if (strap_mux) begin
      h_ad = 8'(a); h_addr = 3'(~a); h_ale = 1'b1;
      repeat (4) @(negedge clk);
      h_ale = 1'b0;
      repeat (4) @(negedge clk);
    end else h_addr = 3'(a);
    if (is_wr) h_ad = d;
    if (strap_rnw) begin
      h_wr_rnw = !is_wr;
      repeat (2) @(negedge clk);
      h_rd_ds_n = 1'b0;
    end else if (is_wr) h_wr_rnw = 1'b0;
    else h_rd_ds_n = 1'b0;
    repeat (hold) @(negedge clk);
    rd = h_data;
    if (!is_wr) check("R6 oe", 32'(h_oe), 1);
    h_rd_ds_n = 1'b1;
    if (!strap_rnw) h_wr_rnw = 1'b1;
    @(negedge clk);
    h_wr_rnw = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_wr(int a, logic [7:0] d, int hold = 4);
    logic [7:0] dummy;
    if (a < 6 && m_mask[a] && wen) exp_wr++;
    host_acc(1'b1, a, d, hold, dummy);
    if (a < 6) begin m_hdr[a] = {8'h00, d}; m_wst[a] = 1'b1; end
    check("R7 irq_wr count", 32'(cnt_wr), 32'(exp_wr));
  endtask

  task automatic host_rd(int a);
    logic [7:0] rd;
    logic [15:0] e;
    e = exp_core(a);
    if (a < 6 && m_mask[8+a] && ren) exp_rd++;
    host_acc(1'b0, a, 8'h00, 4, rd);
    check("R6 host read data", 32'(rd), 32'(e[7:0]));
    if (a < 6) m_rdst[a] = 1'b1;
    check("R8 irq_rd count", 32'(cnt_rd), 32'(exp_rd));
  endtask

  task automatic core_wr(int a, logic [15:0] d);
    @(negedge clk);
    c_addr = 4'(a); c_wdata = d; c_we = 1'b1;
    @(negedge clk);
    c_we = 1'b0;
    if (a < 6) begin m_hdr[a] = d; m_rdst[a] = 1'b0; end
    if (a == 8) m_mask = d;
  endtask

  task automatic core_rd(int a, string req);
    @(negedge clk);
    c_addr = 4'(a); c_re = 1'b1;
    #1 check(req, 32'(c_rdata), 32'(exp_core(a)));
    @(negedge clk);
    c_re = 1'b0;
    if (a < 6) m_wst[a] = 1'b0;
  endtask

  task automatic rst_test(bit from_host);
    int base;
    logic [15:0] d7;
    base = cnt_rst;
    if (from_host) host_wr(7, 8'h80);
    else begin
      core_wr(7, 16'h0080);
      @(negedge clk); c_addr = 4'd7; #1 d7 = c_rdata;
      check("R9 reset bit reads 1", 32'(d7[7]), 1);
    end
    repeat (12) @(negedge clk);
    check(from_host ? "R9 host reset length" : "R9 core reset length", 32'(cnt_rst - base), 5);
    check("R9 pulse ended", 32'(sw_rst), 0);
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6; i++) m_hdr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      c_addr = 4'(a); #1 check("R1 reset value", 32'(c_rdata), 0);
    end
    check("R1 irq/reset low", 32'({irq_wr, irq_rd, sw_rst}), 0);

    core_wr(8, 16'h3f3f); wen = 1'b1; ren = 1'b1;
    // R2 separate strobes: upper byte cleared
    core_wr(2, 16'hffff);
    host_wr(2, 8'ha5);
    core_rd(2, "R2 split write upper cleared");
    check("R5 wst cleared by core read", 32'(m_wst[2]), 0);
    core_rd(6, "R5 write status");
    host_wr(4, 8'h3c);
    core_rd(6, "R5 write status set");
    host_rd(4);
    core_rd(7, "R6 read status set");
    core_wr(4, 16'h1234);
    core_rd(7, "R6 read status cleared by core write");
    // R3 rnw + data strobe
    strap_rnw = 1'b1;
    host_wr(1, 8'h5a);
    core_rd(1, "R3 rnw write");
    host_rd(1);
    // R4 multiplexed bus
    strap_mux = 1'b1;
    host_wr(5, 8'hc3);
    core_rd(5, "R4 mux write");
    host_rd(5);
    strap_rnw = 1'b0;
    host_wr(0, 8'h11);
    core_rd(0, "R4 mux split write");
    strap_mux = 1'b0;
    // R7/R8 masked and disabled
    core_wr(8, 16'h0000);
    host_wr(3, 8'h77); host_rd(3);
    core_wr(8, 16'h3f3f); wen = 1'b0; ren = 1'b0;
    host_wr(3, 8'h78); host_rd(3);
    wen = 1'b1; ren = 1'b1;
    // R10 status writes from host
    host_wr(6, 8'h7f); host_wr(7, 8'h3f);
    core_rd(6, "R10 host write to status");
    core_rd(7, "R10 host write to status");
    // R11 long strobe
    host_wr(0, 8'h99, 40);
    host_rd(0);
    // R9 reset pulse from both sides
    rst_test(1'b0);
    rst_test(1'b1);

    for (int k = 0; k < 250; k++) begin
      int op, a;
      strap_rnw = 1'($urandom_range(0, 1));
      strap_mux = 1'($urandom_range(0, 1));
      wen = 1'($urandom_range(0, 1));
      ren = 1'($urandom_range(0, 1));
      op = $urandom_range(0, 5);
      a = $urandom_range(0, 7);
      case (op)
        0: host_wr(a, (a >= 6) ? 8'($urandom & 32'h7f) : 8'($urandom));
        1: host_rd(a);
        2: if (a < 6) core_wr(a, 16'($urandom)); else core_wr(8, 16'($urandom));
        3: core_rd(a, "R5 R6 random core read");
        4: core_rd((a < 6) ? a : 8, "R7 mask readback");
        default: host_rd(6 + (a & 1));
      endcase
    end
    core_rd(6, "R5 final status");
    core_rd(7, "R6 final status");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule